// File: doc/BRIEF.md
# I2C Serial Memory Slave

This block is the bus-facing half of a 256-byte non-volatile store that sits on a two-wire I2C bus. The store itself is a register array. A system clock samples the serial clock and data lines through a short synchroniser. The block answers only to its own seven-bit device address. A master can use it in four ways:

- write one byte, or up to a page of bytes, at a chosen address;
- read from the current address pointer;
- set the pointer with a write that carries no data, then read after a repeated START;
- keep reading for as long as it acknowledges each byte.

The block drives the data line through an open-drain enable and never drives it high.

A write becomes permanent only at the STOP that closes it. All bytes of the page are committed together. A busy interval then follows, counted in system clocks. During that interval the block does not acknowledge its address, so the master can poll until it answers. A supervisor reset input aborts any bus exchange and blocks new ones while it is active. It also prevents new commits, but a busy interval that has already begun runs to its end.

Top module: `i2c_nvm_slave`

## Requirements
- R1: Bus traffic counts only after a START, which is a falling data line while the clock line is high. A byte clocked in after a STOP without a new START is never acknowledged.
- R2: The device address is the first seven bits after a START, default 1010000. The eighth bit selects read when 1 and write when 0. If the address does not match, the block gives no acknowledge and stays silent until the next START.
- R3: The block acknowledges a matching address, the word address and every data byte by pulling the data line low for the ninth clock. Its data-line drive changes only while the clock line is low.
- R4: A write, meaning address byte 0xA0, then the word address, then one data byte, then STOP, stores that byte at the word address.
- R5: In a page write, each data byte goes to the current pointer. After each byte only the low four pointer bits advance, wrapping within the 16-byte page. Bytes beyond the sixteenth overwrite earlier bytes of the same page, and neighbouring pages are untouched.
- R6: A commit happens only at a STOP that follows at least one data byte. If a repeated START or a STOP comes before any data byte, nothing is stored and no busy interval starts.
- R7: For PROG_CYCLES system clocks after a commit, the block does not acknowledge its address. Once the interval ends, it acknowledges again.
- R8: A current-address read returns the byte at the pointer. After a read the pointer advances across all eight bits, so 0xFF rolls over to 0x00. After a write the pointer holds the next position within the page.
- R9: A random read is a write of the word address, then a repeated START, then address byte 0xA1. It returns the byte at that word address.
- R10: In a sequential read, each master acknowledge brings the next byte. A master no-acknowledge makes the block release the line and wait for a new START.
- R11: While the supervisor reset is high, the block releases the data line, acknowledges no address and discards a pending page, so the STOP that follows stores nothing.
- R12: A busy interval already started runs to completion even while the supervisor reset is high, and the committed data remains readable.
- R13: After system reset the data line is released, the pointer is 0x00 and every array byte is 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rstN | input | 1 | Asynchronous system reset, active low |
| supRst | input | 1 | Supervisor reset active, high |
| sclIn | input | 1 | Serial clock line level |
| sdaIn | input | 1 | Serial data line level as seen on the wire |
| sdaDriveLow | output | 1 | Open-drain enable: 1 pulls the data line low |

## Verification
The bench sets PROG_CYCLES to 3000 system clocks with a quarter bit of eight clocks. At that setting one busy interval spans several complete address polls, so both the refused polls and the first accepted poll appear in one run. A supervisor reset held longer than the busy interval also stays within the run time. The default 256-byte array and 16-byte page are kept. This puts the pointer rollover from 0xFF to 0x00 within reach, and an 18-byte page write shows the in-page wrap.

// File: rtl/nvm_pkg.sv
package nvm_pkg;
  // one-cycle requests from the bus control to the storage datapath
  typedef struct packed {
    logic setPtr;     // load pointer from received word address, empty page
    logic putByte;    // place received byte into page buffer
    logic fetchByte;  // advance pointer after a byte is handed out
    logic commitPage; // STOP seen: commit buffered bytes
    logic dropPage;   // discard buffered bytes
  } nvmStrobe_t;

  typedef enum logic [2:0] {
    ST_IDLE, ST_RECV, ST_ACK, ST_SEND, ST_MACK
  } busState_t;

  typedef enum logic [1:0] {
    RK_DEV, RK_WADDR, RK_DATA
  } recvKind_t;
endpackage

// File: rtl/nvm_line_sync.sv
module nvm_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic sclRaw,
  input  logic sdaRaw,
  output logic sclLvl,
  output logic sdaLvl,
  output logic sclRise,
  output logic sclFall,
  output logic startSeen,
  output logic stopSeen
);
  logic [STAGES-1:0] sclPipe;
  logic [STAGES-1:0] sdaPipe;
  logic sclLast;
  logic sdaLast;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclPipe <= '1;
      sdaPipe <= '1;
      sclLast <= 1'b1;
      sdaLast <= 1'b1;
    end else begin
      sclPipe <= {sclPipe[STAGES-2:0], sclRaw};
      sdaPipe <= {sdaPipe[STAGES-2:0], sdaRaw};
      sclLast <= sclPipe[STAGES-1];
      sdaLast <= sdaPipe[STAGES-1];
    end
  end

  assign sclLvl    = sclPipe[STAGES-1];
  assign sdaLvl    = sdaPipe[STAGES-1];
  assign sclRise   = sclLvl & ~sclLast;
  assign sclFall   = ~sclLvl & sclLast;
  assign startSeen = sclLvl & sclLast & sdaLast & ~sdaLvl;
  assign stopSeen  = sclLvl & sclLast & ~sdaLast & sdaLvl;
endmodule

// File: rtl/nvm_bus_ctrl.sv
module nvm_bus_ctrl
  import nvm_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'h50
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       supRst,
  input  logic       sclLvl,
  input  logic       sdaLvl,
  input  logic       sclRise,
  input  logic       sclFall,
  input  logic       startSeen,
  input  logic       stopSeen,
  input  logic       busy,
  input  logic [7:0] rdByte,
  output nvmStrobe_t strb,
  output logic [7:0] rxByte,
  output logic       driveLow
);
  busState_t state;
  recvKind_t kind;
  logic [3:0] bitCnt;
  logic [7:0] shReg;
  logic [7:0] txReg;
  logic       nextTx;
  logic       masterAck;
  logic       devHit;
  logic       byteDone;

  assign rxByte   = shReg;
  assign devHit   = (shReg[7:1] == DEV_ADDR) && !busy;
  assign byteDone = sclFall && (bitCnt == 4'd8);

  always_comb begin
    strb = '0;
    if (supRst || startSeen) begin
      strb.dropPage = 1'b1;
    end else if (stopSeen) begin
      strb.commitPage = 1'b1;
    end else begin
      case (state)
        ST_RECV: if (byteDone) begin
          if (kind == RK_WADDR) strb.setPtr = 1'b1;
          if (kind == RK_DATA)  strb.putByte = 1'b1;
        end
        ST_ACK:  if (sclFall && nextTx) strb.fetchByte = 1'b1;
        ST_MACK: if (sclFall && masterAck) strb.fetchByte = 1'b1;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      kind      <= RK_DEV;
      bitCnt    <= '0;
      shReg     <= '0;
      txReg     <= '0;
      nextTx    <= 1'b0;
      masterAck <= 1'b0;
      driveLow  <= 1'b0;
    end else if (supRst) begin
      state    <= ST_IDLE;
      driveLow <= 1'b0;
    end else if (startSeen) begin
      state    <= ST_RECV;
      kind     <= RK_DEV;
      bitCnt   <= '0;
      driveLow <= 1'b0;
    end else if (stopSeen) begin
      state    <= ST_IDLE;
      driveLow <= 1'b0;
    end else begin
      case (state)
        ST_RECV: begin
          if (sclRise && bitCnt != 4'd8) begin
            shReg  <= {shReg[6:0], sdaLvl};
            bitCnt <= bitCnt + 4'd1;
          end else if (byteDone) begin
            if (kind == RK_DEV) begin
              if (devHit) begin
                driveLow <= 1'b1;
                state    <= ST_ACK;
                nextTx   <= shReg[0];
                kind     <= RK_WADDR;
              end else begin
                state <= ST_IDLE;
              end
            end else begin
              driveLow <= 1'b1;
              state    <= ST_ACK;
              nextTx   <= 1'b0;
              kind     <= RK_DATA;
            end
          end
        end
        ST_ACK: if (sclFall) begin
          bitCnt <= '0;
          if (nextTx) begin
            txReg    <= rdByte;
            driveLow <= ~rdByte[7];
            state    <= ST_SEND;
          end else begin
            driveLow <= 1'b0;
            state    <= ST_RECV;
          end
        end
        ST_SEND: begin
          if (sclRise) begin
            bitCnt <= bitCnt + 4'd1;
          end else if (sclFall) begin
            if (bitCnt == 4'd8) begin
              driveLow  <= 1'b0;
              masterAck <= 1'b0;
              state     <= ST_MACK;
            end else begin
              driveLow <= ~txReg[6];
              txReg    <= {txReg[6:0], 1'b0};
            end
          end
        end
        ST_MACK: begin
          if (sclRise) begin
            masterAck <= ~sdaLvl;
          end else if (sclFall) begin
            bitCnt <= '0;
            if (masterAck) begin
              txReg    <= rdByte;
              driveLow <= ~rdByte[7];
              state    <= ST_SEND;
            end else begin
              state <= ST_IDLE;
            end
          end
        end
        default: ;
      endcase
    end
  end

  // R3
  sda_scl_low_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(driveLow) |-> (!$past(sclLvl) || $past(supRst) || $past(startSeen) || $past(stopSeen)));

  // R11
  sup_release_chk: assert property (@(posedge clk) disable iff (!rstN)
    supRst |=> !driveLow);

  // R7
  busy_nack_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_RECV && kind == RK_DEV && byteDone && busy && !supRst && !startSeen && !stopSeen)
      |=> (!driveLow && state == ST_IDLE));
endmodule

// File: rtl/nvm_store.sv
module nvm_store
  import nvm_pkg::*;
#(
  parameter int MEM_BYTES   = 256,
  parameter int PAGE_BYTES  = 16,
  parameter int PROG_CYCLES = 50000
) (
  input  logic       clk,
  input  logic       rstN,
  input  nvmStrobe_t strb,
  input  logic [7:0] rxByte,
  output logic [7:0] rdByte,
  output logic       busy
);
  localparam int AW = $clog2(MEM_BYTES);
  localparam int PW = $clog2(PAGE_BYTES);
  localparam int CW = $clog2(PROG_CYCLES + 1);

  logic [7:0]            memArr  [MEM_BYTES];
  logic [7:0]            pageBuf [PAGE_BYTES];
  logic [PAGE_BYTES-1:0] pageFill;
  logic [AW-1:0]         ptr;
  logic [CW-1:0]         progCnt;
  logic                  doCommit;

  assign busy     = (progCnt != '0);
  assign rdByte   = memArr[ptr];
  assign doCommit = strb.commitPage && (|pageFill);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < MEM_BYTES; i++) memArr[i] <= '0;
      for (int i = 0; i < PAGE_BYTES; i++) pageBuf[i] <= '0;
      pageFill <= '0;
      ptr      <= '0;
    end else if (strb.setPtr) begin
      ptr      <= AW'(rxByte);
      pageFill <= '0;
    end else if (strb.putByte) begin
      pageBuf[ptr[PW-1:0]]  <= rxByte;
      pageFill[ptr[PW-1:0]] <= 1'b1;
      ptr <= {ptr[AW-1:PW], ptr[PW-1:0] + PW'(1)};
    end else if (strb.fetchByte) begin
      ptr <= ptr + AW'(1);
    end else if (strb.dropPage) begin
      pageFill <= '0;
    end else if (strb.commitPage) begin
      for (int i = 0; i < PAGE_BYTES; i++)
        if (pageFill[i]) memArr[{ptr[AW-1:PW], PW'(i)}] <= pageBuf[i];
      pageFill <= '0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              progCnt <= '0;
    else if (doCommit)      progCnt <= CW'(PROG_CYCLES);
    else if (progCnt != '0) progCnt <= progCnt - CW'(1);
  end

  // R5
  page_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.putByte |=> ptr[AW-1:PW] == $past(ptr[AW-1:PW]));

  // R8
  read_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.fetchByte |=> ptr == AW'($past(ptr) + AW'(1)));

  // R6
  busy_origin_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(strb.commitPage));

  // R12
  busy_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !strb.commitPage) |=> progCnt == CW'($past(progCnt) - CW'(1)));
endmodule

// File: rtl/i2c_nvm_slave.sv
module i2c_nvm_slave
  import nvm_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR    = 7'h50,
  parameter int         MEM_BYTES   = 256,
  parameter int         PAGE_BYTES  = 16,
  parameter int         PROG_CYCLES = 50000,
  parameter int         SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic supRst,
  input  logic sclIn,
  input  logic sdaIn,
  output logic sdaDriveLow
);
  logic sclLvl, sdaLvl, sclRise, sclFall, startSeen, stopSeen;
  logic busy;
  logic [7:0] rdByte, rxByte;
  nvmStrobe_t strb;

  nvm_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rstN(rstN), .sclRaw(sclIn), .sdaRaw(sdaIn),
    .sclLvl(sclLvl), .sdaLvl(sdaLvl), .sclRise(sclRise), .sclFall(sclFall),
    .startSeen(startSeen), .stopSeen(stopSeen)
  );

  nvm_bus_ctrl #(.DEV_ADDR(DEV_ADDR)) u_ctrl (
    .clk(clk), .rstN(rstN), .supRst(supRst), .sclLvl(sclLvl), .sdaLvl(sdaLvl),
    .sclRise(sclRise), .sclFall(sclFall), .startSeen(startSeen), .stopSeen(stopSeen),
    .busy(busy), .rdByte(rdByte), .strb(strb), .rxByte(rxByte), .driveLow(sdaDriveLow)
  );

  nvm_store #(.MEM_BYTES(MEM_BYTES), .PAGE_BYTES(PAGE_BYTES), .PROG_CYCLES(PROG_CYCLES)) u_store (
    .clk(clk), .rstN(rstN), .strb(strb), .rxByte(rxByte), .rdByte(rdByte), .busy(busy)
  );
endmodule

// File: tb/i2c_nvm_slave_tb.sv
module i2c_nvm_slave_tb;
  localparam int Q    = 8;
  localparam int PROG = 3000;
  // {word address, data}
  localparam logic [15:0] VEC [6] = '{16'h003C, 16'h01A5, 16'h5A96, 16'h7F01, 16'h80FE, 16'hFFC7};

  logic clk = 1'b0, rstN = 1'b0, supRst = 1'b0, scl = 1'b1, sdaM = 1'b1;
  logic sdaDriveLow;
  logic sdaLine;
  assign sdaLine = sdaM & ~sdaDriveLow;
  always #5 clk = ~clk;

  i2c_nvm_slave #(.DEV_ADDR(7'h50), .MEM_BYTES(256), .PAGE_BYTES(16),
                  .PROG_CYCLES(PROG), .SYNC_STAGES(2)) u_dut (
    .clk(clk), .rstN(rstN), .supRst(supRst), .sclIn(scl), .sdaIn(sdaLine),
    .sdaDriveLow(sdaDriveLow));

  int checks = 0, failures = 0, sclHighChanges = 0;
  bit done = 1'b0;
  logic prevDL = 1'b0;
  bit ack;
  int polls;
  logic [7:0] wrBuf [0:31];
  logic [7:0] rdBuf [0:31];
  logic [7:0] pageExp [0:15];

  always @(posedge clk) begin
    if (rstN && !supRst && scl && (sdaDriveLow != prevDL)) sclHighChanges++;
    prevDL <= sdaDriveLow;
  end

  task automatic checkEq(input string tag, input int got, input int exp);
    checks++;
    if (got != exp) begin
      failures++;
      $display("FAIL %s got=%0h exp=%0h", tag, got, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic busStart();
    tick(Q); sdaM = 1'b1; tick(Q); scl = 1'b1; tick(Q); sdaM = 1'b0; tick(Q); scl = 1'b0;
  endtask

  task automatic busStop();
    tick(Q); sdaM = 1'b0; tick(Q); scl = 1'b1; tick(Q); sdaM = 1'b1; tick(Q);
  endtask

  task automatic sendByte(input logic [7:0] b, output bit gotAck);
    for (int i = 7; i >= 0; i--) begin
      tick(Q); sdaM = b[i]; tick(Q); scl = 1'b1; tick(2*Q); scl = 1'b0;
    end
    tick(Q); sdaM = 1'b1; tick(Q); scl = 1'b1; tick(Q);
    gotAck = ~sdaLine;
    tick(Q); scl = 1'b0;
  endtask

  task automatic recvByte(input bit mAck, output logic [7:0] d);
    d = '0;
    for (int i = 0; i < 8; i++) begin
      tick(Q); sdaM = 1'b1; tick(Q); scl = 1'b1; tick(Q);
      d = {d[6:0], sdaLine};
      tick(Q); scl = 1'b0;
    end
    tick(Q); sdaM = ~mAck; tick(Q); scl = 1'b1; tick(2*Q); scl = 1'b0;
  endtask

  task automatic writeBlock(input logic [7:0] wa, input int n, input string tag);
    bit a;
    busStart();
    sendByte(8'hA0, a); checkEq({tag, " dev ack R3"}, a, 1);
    sendByte(wa, a);    checkEq({tag, " waddr ack R3"}, a, 1);
    for (int k = 0; k < n; k++) begin
      sendByte(wrBuf[k], a); checkEq({tag, " data ack R3"}, a, 1);
    end
    busStop();
  endtask

  task automatic randomRead(input logic [7:0] ra, input int n, input string tag);
    bit a;
    logic [7:0] d;
    busStart();
    sendByte(8'hA0, a); checkEq({tag, " dummy dev ack R9"}, a, 1);
    sendByte(ra, a);    checkEq({tag, " dummy waddr ack R9"}, a, 1);
    busStart();
    sendByte(8'hA1, a); checkEq({tag, " read dev ack R9"}, a, 1);
    for (int k = 0; k < n; k++) begin
      recvByte(k != n - 1, d); rdBuf[k] = d;
    end
    busStop();
  endtask

  task automatic currentRead(output logic [7:0] d, output bit a);
    busStart();
    sendByte(8'hA1, a);
    recvByte(1'b0, d);
    busStop();
  endtask

  task automatic pollReady(output int n);
    bit a;
    n = 0;
    do begin
      busStart(); sendByte(8'hA0, a); busStop(); n++;
    end while (!a && n < 100);
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog all requirements got=hung exp=finished");
      summary();
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    tick(10);
    rstN = 1'b1;
    tick(4);
    // R13: reset state
    checkEq("R13 released after reset", sdaDriveLow, 0);
    currentRead(d, ack);
    checkEq("R2 read address acked", ack, 1);
    checkEq("R13 pointer 0 holds zero", d, 8'h00);

    // R1: byte without START
    scl = 1'b0;
    sendByte(8'hA0, ack);
    checkEq("R1 no ack without START", ack, 0);
    busStop();

    // R2: wrong address then ignored byte
    busStart();
    sendByte(8'hA2, ack); checkEq("R2 mismatched address nacked", ack, 0);
    sendByte(8'h00, ack); checkEq("R2 silent until next START", ack, 0);
    busStop();

    // table walk: byte write, poll, random read back
    for (int v = 0; v < 6; v++) begin
      wrBuf[0] = VEC[v][7:0];
      writeBlock(VEC[v][15:8], 1, "R4 byte write");
      pollReady(polls);
      checkEq("R7 busy refuses first poll", int'(polls > 1), 1);
      checkEq("R7 ack after busy", int'(polls < 100), 1);
      randomRead(VEC[v][15:8], 1, "R9");
      checkEq("R4 R9 readback", rdBuf[0], VEC[v][7:0]);
    end

    // R8: pointer after read of 0xFF rolls to 0x00
    currentRead(d, ack);
    checkEq("R8 current read after rollover", d, 8'h3C);
    randomRead(8'hFF, 2, "R8");
    checkEq("R10 first sequential byte", rdBuf[0], 8'hC7);
    checkEq("R8 wrap 0xFF to 0x00", rdBuf[1], 8'h3C);

    // R5: 18-byte page write at 0x34
    for (int k = 0; k < 16; k++) pageExp[k] = 8'h00;
    for (int k = 0; k < 18; k++) begin
      wrBuf[k] = 8'(8'h40 + k);
      pageExp[(4 + k) % 16] = 8'(8'h40 + k);
    end
    writeBlock(8'h34, 18, "R5 page write");
    pollReady(polls);
    checkEq("R7 page commit busy", int'(polls > 1), 1);
    currentRead(d, ack);
    checkEq("R8 pointer after page write", d, pageExp[6]);
    randomRead(8'h30, 17, "R10");
    for (int k = 0; k < 16; k++) checkEq("R5 page content", rdBuf[k], pageExp[k]);
    checkEq("R5 next page untouched", rdBuf[16], 8'h00);

    // R6: repeated START before STOP drops data
    busStart();
    sendByte(8'hA0, ack); sendByte(8'h90, ack); sendByte(8'h11, ack);
    busStart();
    sendByte(8'hA0, ack); checkEq("R6 not busy after dropped data", ack, 1);
    busStop();
    pollReady(polls);
    checkEq("R6 no cycle after dropped write", polls, 1);
    randomRead(8'h90, 1, "R6");
    checkEq("R6 dropped byte not stored", rdBuf[0], 8'h00);
    writeBlock(8'h91, 0, "R6 address only");
    pollReady(polls);
    checkEq("R6 no cycle after address only", polls, 1);

    // R11: supervisor reset aborts a pending write
    busStart();
    sendByte(8'hA0, ack); sendByte(8'h50, ack); sendByte(8'h77, ack);
    supRst = 1'b1;
    tick(5);
    checkEq("R11 line released under reset", sdaDriveLow, 0);
    busStart();
    sendByte(8'hA0, ack); checkEq("R11 address refused under reset", ack, 0);
    busStop();
    supRst = 1'b0;
    tick(Q);
    pollReady(polls);
    checkEq("R11 no cycle started", polls, 1);
    randomRead(8'h50, 1, "R11");
    checkEq("R11 aborted byte not stored", rdBuf[0], 8'h00);

    // R12: running cycle completes during a long supervisor reset
    wrBuf[0] = 8'h5E;
    writeBlock(8'h61, 1, "R12 write");
    supRst = 1'b1;
    tick(PROG + 200);
    supRst = 1'b0;
    tick(Q);
    pollReady(polls);
    checkEq("R12 cycle finished under reset", polls, 1);
    randomRead(8'h61, 1, "R12");
    checkEq("R12 data committed", rdBuf[0], 8'h5E);

    // R3: drive changes only while clock is low
    checkEq("R3 no drive change with SCL high", sclHighChanges, 0);

    done = 1'b1;
    summary();
    $finish;
  end
endmodule